// File: doc/BRIEF.md
# Dual-Rail One-Hot Encoder with Explicit Completion

This block encodes a one-hot selection of four lines into a two-bit binary code, with every signal carried in dual-rail form. Each input line arrives as a true rail, a false rail and a go flag. Each code bit leaves as a true rail and a false rail. A single `done` output reports when a whole result is present (set phase) and when everything has drained back to all-zero (reset phase). Operation alternates strictly between a DATA wavefront, where exactly one rail of each input pair is high and its go flag is 1, and a NULL wavefront, where all rails and go flags are 0.

The function and the completion logic are built apart. For each code bit, the true-rail network is a monotonic OR over the true rails of the input lines whose index has that bit set. Its dual is an AND over the false rails of the same lines. Every network output is a threshold gate with hysteresis: it sets when its set function becomes 1 and clears only once all of its inputs are 0. Each output pair feeds a local OR detector. The detector outputs and the input go flags all meet in one multi-input C-element, whose output is `done`. The gates and the C-element are state-holding elements and are modelled as clocked registers, so a wavefront takes a fixed number of clock cycles to cross the block.

Top module: `dual_rail_encoder`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `outTrue`, `outFalse` and `done` are all 0.
- R2: Input line i is 1 when `inTrue[i]`=1 and `inFalse[i]`=0. With only line i at 1 (all other lines 0, go all 1), `outTrue` equals i as a 2-bit binary number and `outFalse` equals its bitwise complement.
- R3: For no code bit are `outTrue[k]` and `outFalse[k]` both 1 at the same time.
- R4: Output rails follow a DATA input one clock edge after it is applied. `done` rises one edge later.
- R5: `done` rises only when every code bit has one rail at 1 and every input go flag is 1. While any go flag is 0, `done` stays 0 even when the output rails are complete.
- R6: `done` falls only when every output rail and every go flag is 0. Otherwise it holds its value.
- R7: An output rail that is set stays at 1 until every input of its gate has returned to 0. A partial reset of a false-rail gate's inputs leaves the rail at 1.
- R8: One edge after all input rails are 0, every output rail is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the state-holding gates |
| rstN | input | 1 | Active-low synchronous reset to NULL |
| inTrue | input | 4 | True rail of each input line |
| inFalse | input | 4 | False rail of each input line |
| inGo | input | 4 | Go flag per input line: 1 in DATA, 0 in NULL |
| outTrue | output | 2 | True rail of each code bit |
| outFalse | output | 2 | False rail of each code bit |
| done | output | 1 | Completion: 1 after full DATA, 0 after full NULL |

## Verification
Each of the four one-hot selections is applied as DATA and then NULL. This tells apart every code value and both rails of both bits, and it confirms the cycle where `done` rises and falls. In the go-gating patterns the rails are complete while all go flags, or only one of them, are held low. These show that `done` waits for the go flags and not only for the outputs. A partial NULL patterns drops one false rail of a gate while its other input stays high. This separates a gate with hysteresis from a plain combinational one.

// File: rtl/dre_pkg.sv
package dre_pkg;
  parameter int unsigned ENC_INPUTS = 4;
  localparam int unsigned ENC_CODE = $clog2(ENC_INPUTS);

  typedef struct packed {
    logic [ENC_CODE-1:0] hi;
    logic [ENC_CODE-1:0] lo;
  } railStrobe_t;
endpackage

// File: rtl/dre_thresh_gate.sv
module dre_thresh_gate (
  input  logic clk,
  input  logic rstN,
  input  logic setFn,
  input  logic anyIn,
  output logic q
);
  // Sets when the set function is true, clears only once all inputs are 0.
  always_ff @(posedge clk) begin
    if (!rstN)       q <= 1'b0;
    else if (setFn)  q <= 1'b1;
    else if (!anyIn) q <= 1'b0;
  end
endmodule

// File: rtl/dre_rail_net.sv
module dre_rail_net
  import dre_pkg::*;
#(
  parameter int unsigned NumIn = ENC_INPUTS,
  localparam int unsigned NumCode = $clog2(NumIn)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumIn-1:0]   inTrue,
  input  logic [NumIn-1:0]   inFalse,
  output logic [NumCode-1:0] railHi,
  output logic [NumCode-1:0] railLo
);
  logic [NumCode-1:0] setHi, anyHi, setLo, anyLo;

  // True rail of bit k: OR of true rails of lines whose index has bit k set.
  // Dual false rail: AND of the false rails of the same lines.
  always_comb begin
    for (int k = 0; k < NumCode; k++) begin
      setHi[k] = 1'b0;
      anyHi[k] = 1'b0;
      setLo[k] = 1'b1;
      anyLo[k] = 1'b0;
      for (int i = 0; i < NumIn; i++) begin
        if (((i >> k) & 1) == 1) begin
          setHi[k] = setHi[k] | inTrue[i];
          anyHi[k] = anyHi[k] | inTrue[i];
          setLo[k] = setLo[k] & inFalse[i];
          anyLo[k] = anyLo[k] | inFalse[i];
        end
      end
    end
  end

  for (genvar k = 0; k < NumCode; k++) begin : g_bit
    dre_thresh_gate hiGate_i (
      .clk(clk), .rstN(rstN), .setFn(setHi[k]), .anyIn(anyHi[k]), .q(railHi[k])
    );
    dre_thresh_gate loGate_i (
      .clk(clk), .rstN(rstN), .setFn(setLo[k]), .anyIn(anyLo[k]), .q(railLo[k])
    );
  end
endmodule

// File: rtl/dre_completion.sv
module dre_completion
  import dre_pkg::*;
#(
  parameter int unsigned NumIn = ENC_INPUTS
) (
  input  logic             clk,
  input  logic             rstN,
  input  railStrobe_t      rails,
  input  logic [NumIn-1:0] inGo,
  output logic             done
);
  logic [ENC_CODE-1:0] pairDone;
  logic allHigh, allLow;

  always_comb begin
    pairDone = rails.hi | rails.lo;   // local OR detectors
    allHigh  = (&pairDone) & (&inGo);
    allLow   = ~(|pairDone) & ~(|inGo);
  end

  // Multi-input C-element
  always_ff @(posedge clk) begin
    if (!rstN)        done <= 1'b0;
    else if (allHigh) done <= 1'b1;
    else if (allLow)  done <= 1'b0;
  end
endmodule

// File: rtl/dual_rail_encoder.sv
module dual_rail_encoder
  import dre_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ENC_INPUTS-1:0] inTrue,
  input  logic [ENC_INPUTS-1:0] inFalse,
  input  logic [ENC_INPUTS-1:0] inGo,
  output logic [ENC_CODE-1:0]   outTrue,
  output logic [ENC_CODE-1:0]   outFalse,
  output logic                  done
);
  railStrobe_t rails;

  dre_rail_net #(.NumIn(ENC_INPUTS)) net_i (
    .clk(clk), .rstN(rstN), .inTrue(inTrue), .inFalse(inFalse),
    .railHi(rails.hi), .railLo(rails.lo)
  );

  dre_completion #(.NumIn(ENC_INPUTS)) compl_i (
    .clk(clk), .rstN(rstN), .rails(rails), .inGo(inGo), .done(done)
  );

  assign outTrue  = rails.hi;
  assign outFalse = rails.lo;
endmodule

// File: rtl/dual_rail_encoder_chk.sv
module dual_rail_encoder_chk
  import dre_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [ENC_INPUTS-1:0] inTrue,
  input logic [ENC_INPUTS-1:0] inFalse,
  input logic [ENC_INPUTS-1:0] inGo,
  input logic [ENC_CODE-1:0]   outTrue,
  input logic [ENC_CODE-1:0]   outFalse,
  input logic                  done
);
  // R3
  rails_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outTrue & outFalse) == '0);

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(&inGo) && $past(&(outTrue | outFalse))));

  // R6
  done_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> ($past(inGo) == '0 && $past(outTrue | outFalse) == '0));

  // R8
  null_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inTrue == '0 && inFalse == '0) |=> (outTrue == '0 && outFalse == '0));
endmodule

bind dual_rail_encoder dual_rail_encoder_chk chk_i (
  .clk(clk), .rstN(rstN), .inTrue(inTrue), .inFalse(inFalse), .inGo(inGo),
  .outTrue(outTrue), .outFalse(outFalse), .done(done)
);

// File: tb/dual_rail_encoder_tb_top.sv
module dual_rail_encoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] inTrue = '0, inFalse = '0, inGo = '0;
  logic [1:0] outTrue, outFalse;
  logic done;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_rail_encoder dut_i (
    .clk(clk), .rstN(rstN), .inTrue(inTrue), .inFalse(inFalse), .inGo(inGo),
    .outTrue(outTrue), .outFalse(outFalse), .done(done)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveNull();
    inTrue = '0; inFalse = '0; inGo = '0;
  endtask

  task automatic driveData(int idx, logic [3:0] go);
    inTrue = 4'(1 << idx); inFalse = ~4'(1 << idx); inGo = go;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 reset outTrue", {6'd0, outTrue}, 8'd0);
    check("R1 reset outFalse", {6'd0, outFalse}, 8'd0);
    check("R1 reset done", {7'd0, done}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset done", {7'd0, done}, 8'd0);
  endtask

  task automatic testEncode(int idx);
    logic [1:0] code = 2'(idx);
    driveData(idx, 4'hF);
    @(negedge clk);
    check("R2 outTrue", {6'd0, outTrue}, {6'd0, code});
    check("R2 outFalse", {6'd0, outFalse}, {6'd0, ~code});
    check("R4 done not yet", {7'd0, done}, 8'd0);
    @(negedge clk);
    check("R4 done risen", {7'd0, done}, 8'd1);
    driveNull();
    @(negedge clk);
    check("R8 rails drained", {4'd0, outTrue, outFalse}, 8'd0);
    check("R6 done holds", {7'd0, done}, 8'd1);
    @(negedge clk);
    check("R6 done fallen", {7'd0, done}, 8'd0);
  endtask

  task automatic testGoGate(logic [3:0] go);
    driveData(2, go);
    repeat (3) @(negedge clk);
    check("R5 rails complete", {4'd0, outTrue, outFalse}, 8'b0000_1001);
    check("R5 done waits go", {7'd0, done}, 8'd0);
    inGo = 4'hF;
    @(negedge clk);
    check("R5 done after go", {7'd0, done}, 8'd1);
    driveNull();
    repeat (2) @(negedge clk);
    check("R6 drained", {3'd0, done, outTrue, outFalse}, 8'd0);
  endtask

  task automatic testPartialNull();
    driveData(0, 4'hF);
    repeat (2) @(negedge clk);
    check("R7 setup outFalse", {6'd0, outFalse}, 8'd3);
    inFalse[2] = 1'b0; inGo[2] = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 outFalse held", {6'd0, outFalse}, 8'd3);
    check("R6 done held partial", {7'd0, done}, 8'd1);
    driveNull();
    @(negedge clk);
    check("R7 outFalse cleared", {6'd0, outFalse}, 8'd0);
    @(negedge clk);
    check("R6 done cleared", {7'd0, done}, 8'd0);
  endtask

  initial begin
    testReset();
    for (int i = 0; i < 4; i++) testEncode(i);
    testGoGate(4'h0);
    testGoGate(4'b1011);
    testPartialNull();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule